// File: doc/BRIEF.md
# Calibration Capture and Inverse Table Builder

This block turns two open-loop calibration runs of a process into lookup tables that undo the process response. A symbol sequencer provides the time base. It walks through the 256 symbol positions of one run, and each position lasts a programmable number of clock cycles. On the first cycle of each position the block stores the present input-converter symbol and output-converter symbol at that position. One run is made with a rising test signal and one with a falling test signal, which gives four capture memories.

A build command then creates two inverse tables:
- the input inverse table maps an input symbol back to the step at which it was captured;
- the output inverse table does the same for output symbols.

Both tables are first preset to a gap value. The falling run is then written into them, and the rising run is written after it. Last, the block composes a third table, which holds the input inverse evaluated at the output inverse of each index. A registered read port returns any of the seven tables once the block is idle.

Symbols 1 to 256 are carried as 8-bit codes equal to the symbol minus one. Step position k (code k, 0 to 255) therefore stands for symbol k+1. The midpoint symbol 129 is code 128, and the gap symbol 128 is code 127.

Top module: `caltab_inverter`

## Requirements
- R1: A start with cmd 0 (rising run) or cmd 1 (falling run) begins a capture. For each step code k from 0 to 255, in_sym and out_sym are written at address k. A rising run writes the rising-input table (read select 0) and the rising-output table (read select 1). A falling run writes the falling-input table (read select 2) and the falling-output table (read select 3).
- R2: Each step lasts step_div+1 clock cycles, with step_div latched when the start is accepted. Only the first cycle of each step is sampled. A capture keeps busy high for 256*(step_div+1) cycles.
- R3: A start while busy is high is ignored whatever its cmd: no table changes, and the running pass continues unchanged.
- R4: Every build first presets all 256 entries of both inverse tables to code 127. An entry that no capture writes reads 127 afterwards, even if an earlier build had filled it.
- R5: The inverse pass writes step code k to input-inverse[input symbol at step k] and to output-inverse[output symbol at step k]. The falling run is written first and the rising run second. Within a run the steps go in rising k order, so later steps win, and rising data wins over falling data.
- R6: The composed table holds, at each index k, input-inverse[output-inverse[k]].
- R7: A build (cmd 2 or 3) keeps busy high for exactly 1024 cycles. It then raises done, which stays high until the next accepted start clears it.
- R8: rd_sel selects the table to read: 0 to 3 are the capture tables of R1, 4 is the input inverse, 5 is the output inverse, 6 is the composed table and 7 reads zero. rd_data shows the entry at rd_addr one clock after rd_sel and rd_addr are applied.
- R9: While reset is held, and after it, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a pass; taken only while idle |
| cmd | input | 2 | 0 rising capture, 1 falling capture, 2 or 3 build |
| step_div | input | 16 | Extra cycles per capture step (step length is step_div+1) |
| in_sym | input | 8 | Input-converter symbol code |
| out_sym | input | 8 | Output-converter symbol code |
| rd_sel | input | 3 | Table select for the read port |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | A capture or build pass is running |
| done | output | 1 | Last build finished; cleared by an accepted start |

## Verification
The hardest cases to reach are overwrites inside the inverse tables. These are rising data landing on entries the falling run already wrote, later steps replacing earlier ones in the same run, and gaps that a previous build had filled and that must revert to the gap code. The stimulus reaches all three. The captured input ramps overlap by a few codes and advance one code every several steps. The output patterns of the two runs collide on every entry. A second build uses a rising run whose codes sit in a different range.

The second capture also runs with a step length of three cycles. During the two unsampled cycles of each step the bench drives decoy symbols, and in one of those cycles it issues a conflicting start. This shows that only the first cycle is stored and that the busy lockout protects the falling tables.

// File: rtl/caltab_pkg.sv
package caltab_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CAP,
      PH_PRESET,
      PH_INV_F,
      PH_INV_R,
      PH_COMP
   } phase_t;

   localparam int CAP_SLOTS = 4;

   localparam logic [2:0] RSEL_MI = 3'd4;
   localparam logic [2:0] RSEL_MO = 3'd5;
   localparam logic [2:0] RSEL_IO = 3'd6;

endpackage

// File: rtl/caltab_seq.sv
module caltab_seq #(
   parameter int AW    = 8,
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] lim,
   output logic [AW-1:0]    step,
   output logic             tick,
   output logic             wrap
);

   logic [DIV_W-1:0] div_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_cnt <= '0;
         step    <= '0;
      end else if (en) begin
         if (div_cnt == lim) begin
            div_cnt <= '0;
            step    <= step + 1'b1;
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end
   end

   assign tick = en && (div_cnt == '0);
   assign wrap = en && (div_cnt == lim) && (step == '1);

   // R2: an idle sequencer always rests at the start of step 0
   p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (step == '0 && div_cnt == '0));

   // R2: with a multi-cycle step, the sampling strobe never repeats back to back
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && lim != '0) |=> !tick);

endmodule

// File: rtl/caltab_ram.sv
module caltab_ram #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/caltab_inverter.sv
module caltab_inverter
   import caltab_pkg::*;
#(
   parameter int              SYM_W    = 8,
   parameter int              DIV_W    = 16,
   parameter logic [SYM_W-1:0] GAP_CODE = 8'd127,
   parameter bit              RD_REG   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       cmd,
   input  logic [DIV_W-1:0] step_div,
   input  logic [SYM_W-1:0] in_sym,
   input  logic [SYM_W-1:0] out_sym,
   input  logic [2:0]       rd_sel,
   input  logic [SYM_W-1:0] rd_addr,
   output logic [SYM_W-1:0] rd_data,
   output logic             busy,
   output logic             done
);

   localparam int DEPTH = 1 << SYM_W;

   initial begin
      a_width_ok: assert (SYM_W >= 2 && SYM_W <= 12)
         else $error("SYM_W out of range");
      a_gap_ok: assert (int'(GAP_CODE) < DEPTH)
         else $error("GAP_CODE outside the table");
      a_div_ok: assert (DIV_W >= 1)
         else $error("DIV_W must be positive");
   end

   phase_t           phase;
   logic             run_fall;
   logic [DIV_W-1:0] lim_q;
   logic             done_q;
   logic             accept;

   logic [SYM_W-1:0] step;
   logic             tick;
   logic             wrap;
   logic [DIV_W-1:0] seq_lim;

   assign accept  = start && (phase == PH_IDLE);
   assign seq_lim = (phase == PH_CAP) ? lim_q : '0;

   caltab_seq #(.AW(SYM_W), .DIV_W(DIV_W)) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (phase != PH_IDLE),
      .lim  (seq_lim),
      .step (step),
      .tick (tick),
      .wrap (wrap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         run_fall <= 1'b0;
         lim_q    <= '0;
         done_q   <= 1'b0;
      end else if (accept) begin
         done_q <= 1'b0;
         lim_q  <= step_div;
         if (cmd[1]) begin
            phase <= PH_PRESET;
         end else begin
            phase    <= PH_CAP;
            run_fall <= cmd[0];
         end
      end else if (wrap) begin
         case (phase)
            PH_CAP:    phase <= PH_IDLE;
            PH_PRESET: phase <= PH_INV_F;
            PH_INV_F:  phase <= PH_INV_R;
            PH_INV_R:  phase <= PH_COMP;
            PH_COMP: begin
               phase  <= PH_IDLE;
               done_q <= 1'b1;
            end
            default:   phase <= PH_IDLE;
         endcase
      end
   end

   // capture memories: slot 0 rise-in, 1 rise-out, 2 fall-in, 3 fall-out
   logic             inv_pass;
   logic [SYM_W-1:0] cap_ra;
   logic [CAP_SLOTS-1:0] cap_we;
   logic [SYM_W-1:0] cap_rd [CAP_SLOTS];

   assign inv_pass = (phase == PH_INV_F) || (phase == PH_INV_R);
   assign cap_ra   = inv_pass ? step : rd_addr;

   for (genvar gi = 0; gi < CAP_SLOTS; gi++) begin : g_cap
      localparam bit SLOT_FALL = (gi >= 2);
      localparam bit SLOT_OUT  = (gi % 2) == 1;
      assign cap_we[gi] = tick && (phase == PH_CAP) && (run_fall == SLOT_FALL);
      caltab_ram #(.AW(SYM_W), .DW(SYM_W)) u_ram (
         .clk  (clk),
         .we   (cap_we[gi]),
         .waddr(step),
         .wdata(SLOT_OUT ? out_sym : in_sym),
         .raddr(cap_ra),
         .rdata(cap_rd[gi])
      );
   end

   // inverse and composed tables
   logic             preset;
   logic [SYM_W-1:0] src_in, src_out;
   logic [SYM_W-1:0] mi_rd, mo_rd, io_rd;

   assign preset  = (phase == PH_PRESET);
   assign src_in  = (phase == PH_INV_F) ? cap_rd[2] : cap_rd[0];
   assign src_out = (phase == PH_INV_F) ? cap_rd[3] : cap_rd[1];

   caltab_ram #(.AW(SYM_W), .DW(SYM_W)) u_mi (
      .clk  (clk),
      .we   (preset || inv_pass),
      .waddr(preset ? step : src_in),
      .wdata(preset ? GAP_CODE : step),
      .raddr((phase == PH_COMP) ? mo_rd : rd_addr),
      .rdata(mi_rd)
   );

   caltab_ram #(.AW(SYM_W), .DW(SYM_W)) u_mo (
      .clk  (clk),
      .we   (preset || inv_pass),
      .waddr(preset ? step : src_out),
      .wdata(preset ? GAP_CODE : step),
      .raddr((phase == PH_COMP) ? step : rd_addr),
      .rdata(mo_rd)
   );

   caltab_ram #(.AW(SYM_W), .DW(SYM_W)) u_io (
      .clk  (clk),
      .we   (phase == PH_COMP),
      .waddr(step),
      .wdata(mi_rd),
      .raddr(rd_addr),
      .rdata(io_rd)
   );

   // read port
   logic [SYM_W-1:0] rd_mux;

   always_comb begin
      case (rd_sel)
         RSEL_MI: rd_mux = mi_rd;
         RSEL_MO: rd_mux = mo_rd;
         RSEL_IO: rd_mux = io_rd;
         3'd7:    rd_mux = '0;
         default: rd_mux = cap_rd[rd_sel[1:0]];
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      logic [SYM_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = rd_mux;
   end

   assign busy = (phase != PH_IDLE);
   assign done = done_q;

   // R3: a running pass keeps the run selection and step length it started with
   p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(run_fall) && $stable(lim_q)));

   // R4: the falling inverse pass is always entered straight from the preset pass
   p_preset_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INV_F && $past(phase) != PH_INV_F) |-> $past(phase) == PH_PRESET);

   // R5: rising data is written only after the falling pass
   p_rise_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INV_R && $past(phase) != PH_INV_R) |-> $past(phase) == PH_INV_F);

   // R7: done rises only as the composition pass closes
   p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(phase) == PH_COMP);

endmodule

// File: tb/caltab_inverter_tb.sv
module caltab_inverter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  cmd = 2'd0;
   logic [15:0] step_div = 16'd0;
   logic [7:0]  in_sym = 8'd0;
   logic [7:0]  out_sym = 8'd0;
   logic [2:0]  rd_sel = 3'd0;
   logic [7:0]  rd_addr = 8'd0;
   logic [7:0]  rd_data;
   logic        busy, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int cap_m [4][256];
   int mi_m [256];
   int mo_m [256];
   int io_m [256];

   always #10 clk = ~clk;

   caltab_inverter u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .step_div(step_div),
      .in_sym(in_sym), .out_sym(out_sym), .rd_sel(rd_sel), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy), .done(done)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int pat(int id, bit outp, int k);
      case (id)
         0: return outp ? ((3 * k) & 255) : (128 + k / 4);
         1: return outp ? (k / 2) : (130 - k / 4);
         default: return outp ? k : (255 - k / 8);
      endcase
   endfunction

   task automatic issue(int c, int dv);
      start = 1'b1; cmd = 2'(c); step_div = 16'(dv);
      @(posedge clk); @(negedge clk);
      start = 1'b0;
   endtask

   task automatic capture(int id, bit fall, int dv, bit decoy_start);
      int p = dv + 1;
      issue(fall ? 1 : 0, dv);
      chk("R2 busy after capture start", busy, 1);
      chk("R7 done cleared by start", done, 0);
      for (int k = 0; k < 256; k++) begin
         in_sym  = 8'(pat(id, 1'b0, k));
         out_sym = 8'(pat(id, 1'b1, k));
         if (k == 255) chk("R2 busy through last step", busy, 1);
         @(posedge clk); @(negedge clk);
         if (p > 1) begin
            in_sym  = 8'(8'hA5 ^ k);
            out_sym = 8'(8'h3C ^ k);
            if (decoy_start && k == 10) begin
               start = 1'b1; cmd = 2'd1; step_div = 16'd0;
            end
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            for (int j = 0; j < p - 2; j++) begin
               @(posedge clk); @(negedge clk);
            end
         end
      end
      chk("R2 capture length", busy, 0);
      for (int k = 0; k < 256; k++) begin
         cap_m[fall ? 2 : 0][k] = pat(id, 1'b0, k);
         cap_m[fall ? 3 : 1][k] = pat(id, 1'b1, k);
      end
   endtask

   task automatic model_build();
      for (int k = 0; k < 256; k++) begin mi_m[k] = 127; mo_m[k] = 127; end
      for (int k = 0; k < 256; k++) begin mi_m[cap_m[2][k]] = k; mo_m[cap_m[3][k]] = k; end
      for (int k = 0; k < 256; k++) begin mi_m[cap_m[0][k]] = k; mo_m[cap_m[1][k]] = k; end
      for (int k = 0; k < 256; k++) io_m[k] = mi_m[mo_m[k]];
   endtask

   task automatic build();
      int early = 0;
      issue(2, 0);
      for (int n = 1; n < 1024; n++) begin
         if (busy !== 1'b1) early++;
         if (n == 500) begin start = 1'b1; cmd = 2'd0; end
         if (n == 501) start = 1'b0;
         @(posedge clk); @(negedge clk);
      end
      chk("R7 busy held for whole build", early, 0);
      chk("R7 done low before end", done, 0);
      @(posedge clk); @(negedge clk);
      chk("R7 busy low after 1024 cycles", busy, 0);
      chk("R7 done after build", done, 1);
      model_build();
   endtask

   task automatic rd(int sel, int a, output int d);
      rd_sel = 3'(sel); rd_addr = 8'(a);
      @(posedge clk); @(negedge clk);
      d = rd_data;
   endtask

   task automatic check_tables(bit with_inv);
      int d;
      for (int s = 0; s < (with_inv ? 7 : 4); s++) begin
         for (int a = 0; a < 256; a++) begin
            rd(s, a, d);
            case (s)
               0, 1, 2, 3: chk($sformatf("R1 R3 R8 cap%0d[%0d]", s, a), d, cap_m[s][a]);
               4: chk($sformatf("R4 R5 R8 inv_in[%0d]", a), d, mi_m[a]);
               5: chk($sformatf("R4 R5 R8 inv_out[%0d]", a), d, mo_m[a]);
               default: chk($sformatf("R6 R8 comp[%0d]", a), d, io_m[a]);
            endcase
         end
      end
      rd(7, 0, d);
      chk("R8 select 7 reads zero", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 busy in reset", busy, 0);
      chk("R9 done in reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 busy after reset", busy, 0);
      chk("R9 done after reset", done, 0);

      capture(1, 1'b1, 0, 1'b0);
      capture(0, 1'b0, 0, 1'b0);
      chk("R7 no done after capture", done, 0);
      check_tables(1'b0);
      build();
      check_tables(1'b1);

      capture(2, 1'b0, 2, 1'b1);
      chk("R7 done cleared by capture", done, 0);
      check_tables(1'b0);
      build();
      check_tables(1'b1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule